// File: doc/BRIEF.md
# Thread-Aware Direct-Mapped Branch Target Buffer

This block caches branch targets for a fetch unit that is shared by several hardware threads. Each entry holds a valid flag, a tag, the ID of the thread that wrote it, and a target address. The table is direct-mapped. The entry is chosen from the word-aligned fetch address, and the requesting thread ID is folded into the upper index bits by XOR. This spreads threads that run the same code across different entries.

A lookup is purely combinational. It returns a hit flag and the stored target in the same cycle, and the target reads as zero on a miss. An update writes one entry on the next rising edge and never checks what was there before. Updates arrive on a valid-only port and are always accepted, so the block applies no back-pressure and has no ready signal. The lookup side has no handshake either: it is evaluated on every cycle.

The entry count must be a power of two, and elaboration stops otherwise. The thread count must not exceed the entry count. With a single thread, the thread term drops out and the index is the plain address slice.

Top module: `btb_mt`

## Requirements
- R1: The entry index is ((lk_pc >> ALIGN_SH) XOR (tid << (log2 ENTRIES − log2 THREADS))), cut to log2 ENTRIES bits. With the bench parameters this is index = pc[5:2] XOR (tid << 2).
- R2: The tag is pc >> (ALIGN_SH + log2 ENTRIES), cut to TAG_W bits (pc[13:6] in the bench). Address bits above the tag and below ALIGN_SH do not affect a hit.
- R3: lk_hit is 1 only when three conditions all hold for the indexed entry: it is valid, its stored tag equals the computed tag, and its stored thread ID equals lk_tid.
- R4: When lk_hit is 0, lk_tgt is all zeros. When lk_hit is 1, lk_tgt is the stored target.
- R5: When upd_valid is 1 at a rising edge, the indexed entry is overwritten with no hit check. The write stores the thread ID, tag and target and sets valid. A lookup of that PC and thread hits with the new target from the next cycle on.
- R6: The lookup is combinational. If an update and a lookup address the same entry in one cycle, the lookup returns the contents from before the write.
- R7: When rst_n is low at a rising edge, every entry is invalidated, and no lookup hits until a new update is made.
- R8: When reset and an update occur in the same cycle, reset wins, and the updated entry stays invalid.
- R9: When upd_valid is 0, no entry changes. Lookups that hit before still hit with the same target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset that invalidates all entries |
| lk_pc | input | PC_W | Lookup fetch address |
| lk_tid | input | TID_W | Lookup thread ID |
| lk_hit | output | 1 | Lookup hit |
| lk_tgt | output | TGT_W | Lookup target, or zero on a miss |
| upd_valid | input | 1 | Update request, always accepted |
| upd_pc | input | PC_W | Address of the branch being written |
| upd_tid | input | TID_W | Thread ID that owns the new entry |
| upd_tgt | input | TGT_W | Target to store |

## Verification
The bench builds the block with 16 entries, a 2-bit alignment shift, an 8-bit tag, 4 threads and 32-bit addresses and targets. With these values the thread XOR lands on index bits 2 and 3. Flipping address bit 4 while changing the thread from 0 to 1 therefore reaches the same entry with the same tag, so a thread-ID mismatch can be separated from a tag mismatch. The narrow tag leaves address bits 14 and up outside the compare, which lets the bench show aliasing on high bits.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Width of a thread-ID field: at least one bit even for a single thread.
  function automatic int tid_width(input int threads);
    return (threads > 1) ? $clog2(threads) : 1;
  endfunction

  // log2 of the thread count; zero for a single thread.
  function automatic int thr_log2(input int threads);
    return (threads > 1) ? $clog2(threads) : 0;
  endfunction

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/btb_hash.sv
module btb_hash #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 8,
  parameter int THREADS = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TID_W  = btb_pkg::tid_width(THREADS),
  localparam int THR_LG = btb_pkg::thr_log2(THREADS),
  localparam int SH     = IDX_W - THR_LG
) (
  input  logic [IDX_W+TAG_W-1:0] word_bits,  // address already shifted by the alignment
  input  logic [TID_W-1:0]       tid,
  output logic [IDX_W-1:0]       idx,
  output logic [TAG_W-1:0]       tag
);
  logic [IDX_W+TID_W-1:0] tid_wide;

  always_comb begin
    tid_wide = {{IDX_W{1'b0}}, tid} << SH;
    idx      = word_bits[IDX_W-1:0] ^ tid_wide[IDX_W-1:0];
    tag      = word_bits[IDX_W +: TAG_W];
  end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 8,
  parameter int TGT_W   = 32,
  parameter int THREADS = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TID_W  = btb_pkg::tid_width(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic [TID_W-1:0] wtid,
  input  logic [TGT_W-1:0] wtgt,
  input  logic [IDX_W-1:0] ridx,
  output logic             rvalid,
  output logic [TAG_W-1:0] rtag,
  output logic [TID_W-1:0] rtid,
  output logic [TGT_W-1:0] rtgt
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TID_W-1:0]   tid_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q [ENTRIES];

  // Valid bits reset; payload arrays do not.
  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (we) valid_q[widx] <= 1'b1;
  end

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst_n && we && (widx == IDX_W'(e))) begin
          tag_q[e] <= wtag;
          tid_q[e] <= wtid;
          tgt_q[e] <= wtgt;
        end
      end
    end
  endgenerate

  // Asynchronous read of registered state: old contents during a write.
  always_comb begin
    rvalid = valid_q[ridx];
    rtag   = tag_q[ridx];
    rtid   = tid_q[ridx];
    rtgt   = tgt_q[ridx];
  end

  // R5
  wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> valid_q[$past(widx)]);

  // R9
  idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && $past(rst_n)) |=> $stable(valid_q));

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (valid_q == '0));
endmodule

// File: rtl/btb_mt.sv
module btb_mt #(
  parameter int ENTRIES  = 16,
  parameter int TAG_W    = 8,
  parameter int ALIGN_SH = 2,
  parameter int THREADS  = 4,
  parameter int PC_W     = 32,
  parameter int TGT_W    = 32,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TID_W   = btb_pkg::tid_width(THREADS),
  localparam int SLICE_W = IDX_W + TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [TID_W-1:0] lk_tid,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_tgt,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [TID_W-1:0] upd_tid,
  input  logic [TGT_W-1:0] upd_tgt
);
  generate
    if (!btb_pkg::is_pow2(ENTRIES)) begin : g_bad_entries
      $error("btb_mt: ENTRIES must be a power of two");
    end
    if (THREADS > ENTRIES) begin : g_bad_threads
      $error("btb_mt: THREADS must not exceed ENTRIES");
    end
    if (ALIGN_SH + SLICE_W > PC_W) begin : g_bad_width
      $error("btb_mt: PC_W too narrow for alignment, index and tag");
    end
  endgenerate

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  btb_hash #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .THREADS(THREADS)) u_lk_hash (
    .word_bits (lk_pc[ALIGN_SH +: SLICE_W]),
    .tid       (lk_tid),
    .idx       (lk_idx),
    .tag       (lk_tag)
  );

  btb_hash #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .THREADS(THREADS)) u_up_hash (
    .word_bits (upd_pc[ALIGN_SH +: SLICE_W]),
    .tid       (upd_tid),
    .idx       (up_idx),
    .tag       (up_tag)
  );

  logic             e_valid;
  logic [TAG_W-1:0] e_tag;
  logic [TID_W-1:0] e_tid;
  logic [TGT_W-1:0] e_tgt;

  btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W), .THREADS(THREADS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (upd_valid),
    .widx   (up_idx),
    .wtag   (up_tag),
    .wtid   (upd_tid),
    .wtgt   (upd_tgt),
    .ridx   (lk_idx),
    .rvalid (e_valid),
    .rtag   (e_tag),
    .rtid   (e_tid),
    .rtgt   (e_tgt)
  );

  always_comb begin
    lk_hit = e_valid && (e_tag == lk_tag) && (e_tid == lk_tid);
    lk_tgt = lk_hit ? e_tgt : '0;
  end

  // R5
  upd_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (((lk_pc == $past(upd_pc)) && (lk_tid == $past(upd_tid)))
                   -> (lk_hit && (lk_tgt == $past(upd_tgt)))));

  // R7
  no_hit_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);
endmodule

// File: tb/btb_mt_tb.sv
module btb_mt_tb;
  localparam int ENT = 16, TAGW = 8, AL = 2, THR = 4, PCW = 32, TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PCW-1:0] lk_pc = '0, upd_pc = '0;
  logic [1:0]     lk_tid = '0, upd_tid = '0;
  logic           lk_hit, upd_valid = 1'b0;
  logic [TW-1:0]  lk_tgt, upd_tgt = '0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // Reference table built from the requirements.
  bit         m_v   [ENT];
  int         m_tag [ENT];
  int         m_tid [ENT];
  logic [31:0] m_tgt [ENT];

  always #2 clk = ~clk;

  btb_mt #(.ENTRIES(ENT), .TAG_W(TAGW), .ALIGN_SH(AL), .THREADS(THR),
           .PC_W(PCW), .TGT_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_tid(lk_tid),
    .lk_hit(lk_hit), .lk_tgt(lk_tgt), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_tid(upd_tid), .upd_tgt(upd_tgt));

  function automatic int bidx(logic [31:0] pc, int tid);
    return int'(((pc >> AL) ^ (32'(tid) << 2)) & 32'(ENT - 1));
  endfunction

  function automatic int btag(logic [31:0] pc);
    return int'((pc >> (AL + 4)) & 32'hFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive a lookup and compare hit/target with the reference table.
  task automatic look(string req, logic [31:0] pc, int tid);
    int i;
    bit eh;
    logic [31:0] et;
    lk_pc = pc; lk_tid = 2'(tid);
    #1;
    i  = bidx(pc, tid);
    eh = m_v[i] && (m_tag[i] == btag(pc)) && (m_tid[i] == tid);
    et = eh ? m_tgt[i] : 32'h0;
    check(req, 32'(lk_hit), 32'(eh), "hit");
    check(req, lk_tgt, et, "target");
  endtask

  task automatic write(logic [31:0] pc, int tid, logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_tid = 2'(tid); upd_tgt = tgt;
    @(posedge clk);
    if (rst_n) begin
      m_v[bidx(pc, tid)]   = 1'b1;
      m_tag[bidx(pc, tid)] = btag(pc);
      m_tid[bidx(pc, tid)] = tid;
      m_tgt[bidx(pc, tid)] = tgt;
    end
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    foreach (m_v[k]) m_v[k] = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    look("R7", 32'h0000_1230, 0);
    look("R4", 32'h0000_0000, 0);
  endtask

  task automatic t_basic();
    write(32'h0000_1230, 0, 32'hAAAA_0001);
    look("R5", 32'h0000_1230, 0);
    look("R4", 32'h0000_1230, 0);
    // same index, same tag, other thread: stored thread mismatch
    look("R3", 32'h0000_1230 ^ 32'h10, 1);
    check("R3", 32'(lk_hit), 32'h0, "thread mismatch hit");
    // same index, other tag
    look("R3", 32'h0000_1270, 0);
    check("R3", 32'(lk_hit), 32'h0, "tag mismatch hit");
  endtask

  task automatic t_index_hash();
    // pc word index 5, tid 2 -> entry 5 ^ 8 = 13
    write(32'h0000_0014, 2, 32'hBEEF_0002);
    check("R1", 32'(bidx(32'h14, 2)), 32'd13, "model index");
    look("R1", 32'h0000_0014, 2);
    check("R1", 32'(lk_hit), 32'h1, "hashed hit");
    // same pc from thread 0 sits in entry 5 and coexists
    write(32'h0000_0014, 0, 32'hBEEF_0000);
    look("R1", 32'h0000_0014, 0);
    look("R1", 32'h0000_0014, 2);
    check("R1", lk_tgt, 32'hBEEF_0002, "thread 2 target kept");
  endtask

  task automatic t_tag_bits();
    write(32'h0000_2248, 1, 32'hC0DE_0003);
    look("R2", 32'h0000_2248 | 32'h0010_0000, 1);
    check("R2", 32'(lk_hit), 32'h1, "high bits ignored");
    look("R2", 32'h0000_2248 | 32'h3, 1);
    check("R2", 32'(lk_hit), 32'h1, "low bits ignored");
  endtask

  task automatic t_overwrite();
    write(32'h0000_1230, 0, 32'hAAAA_0001);
    write(32'h0000_5630, 0, 32'hDDDD_0004); // same entry, new tag
    look("R5", 32'h0000_1230, 0);
    check("R5", 32'(lk_hit), 32'h0, "old branch evicted");
    look("R5", 32'h0000_5630, 0);
    check("R5", lk_tgt, 32'hDDDD_0004, "new target");
  endtask

  task automatic t_rbw();
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_5630; upd_tid = 2'd0; upd_tgt = 32'hEEEE_0005;
    look("R6", 32'h0000_5630, 0);
    check("R6", lk_tgt, 32'hDDDD_0004, "old value same cycle");
    @(posedge clk);
    m_tgt[bidx(32'h5630, 0)] = 32'hEEEE_0005;
    @(negedge clk);
    upd_valid = 1'b0;
    look("R6", 32'h0000_5630, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    upd_pc = 32'h0000_5630; upd_tid = 2'd0; upd_tgt = 32'h1111_1111;
    repeat (3) @(negedge clk);
    look("R9", 32'h0000_5630, 0);
    check("R9", lk_tgt, 32'hEEEE_0005, "unchanged without valid");
  endtask

  task automatic t_reset_clear();
    do_reset();
    look("R7", 32'h0000_5630, 0);
    check("R7", 32'(lk_hit), 32'h0, "cleared by reset");
    look("R7", 32'h0000_0014, 2);
  endtask

  task automatic t_reset_prio();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b1; upd_pc = 32'h0000_0800; upd_tid = 2'd3; upd_tgt = 32'h7777_0007;
    @(negedge clk);
    upd_valid = 1'b0; rst_n = 1'b1;
    look("R8", 32'h0000_0800, 3);
    check("R8", 32'(lk_hit), 32'h0, "reset beats update");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    foreach (m_v[k]) m_v[k] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_basic();
    t_index_hash();
    t_tag_bits();
    t_overwrite();
    t_rbw();
    t_idle();
    t_reset_clear();
    t_reset_prio();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule